// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O controller for 96 pins. The pins are grouped into three banks of 32. Each pin can act as an input or as a driven output. Output values are changed through separate write-one-to-set and write-one-to-clear registers, so software never has to read, modify and write back a shared output word. Pads, muxing and drive strength are outside the block. The pins appear as plain input, output and output-enable vectors.

Every pin can raise an event on a rising edge, a falling edge, a high level or a low level. Each trigger has its own enable bit. A per-pin inversion is applied before detection. Events collect in a sticky status register per bank. Software clears a status bit by writing one to it. A single interrupt line reports whether any status bit in any bank is pending. Inputs pass through a synchronizer before any detection or readback.

The register bus is a simple 32-bit one. A write takes effect on the clock edge where the write enable is sampled. Read data is registered and appears in the cycle after the read enable.

Top module: `gpio_bank_ctl`

## Requirements
- R1: A register's byte address is type*16 + bank*4, for banks 0 to 2. The type codes are: 0 direction, 1 inversion, 2 pin level, 3 output set, 4 output clear, 5 rise enable, 6 fall enable, 7 high enable, 8 low enable, 9 status, 10 kind. Bit n of a bank's register belongs to pin bank*32+n.
- R2: After reset, every register reads zero, `gpio_o` and `gpio_oe_o` are zero, and `irq_o` is low.
- R3: A direction bit of 1 makes the pin an output. `gpio_oe_o` follows the direction register and changes only after a write.
- R4: Writing ones to the output-set register sets those output bits. Writing ones to the output-clear register clears them. Bits written as zero keep their value, and `gpio_o` changes only after a write.
- R5: The pin-level register returns the driven value for output pins and the synchronized input for input pins. Read data appears in the cycle after `rd_en_i` and is zero in any cycle that follows no read.
- R6: An input change made between two clock edges can set a status bit no earlier than the third rising clock edge after it.
- R7: A rising edge of the inverted input sets the pin's status bit when its rise enable is set. A falling edge does the same when its fall enable is set. With both edge enables clear, transitions set nothing.
- R8: A high level of the inverted input sets status when the high enable is set. A low level does the same when the low enable is set. The inversion register selects which pad level counts as high.
- R9: Writing a one to a status bit clears only that bit. Bits written as zero are unaffected. A level-triggered bit whose condition still holds sets again one cycle after the clear.
- R10: The kind register reads 1 for a pending bit whose latest event was an edge. It reads 0 for a pending bit whose latest event was a level, and 0 for a bit that is not pending.
- R11: `irq_o` is high exactly when any status bit in any bank is set. It falls only after a status-clearing write.
- R12: Accesses with a nonzero low address pair, bank field 3, or type 11 or above read zero, and writes to them change nothing. Writes to the pin-level and kind registers are ignored. The set and clear registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| gpio_i | input | 96 | Pad input levels |
| gpio_o | output | 96 | Output values |
| gpio_oe_o | output | 96 | Output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: three banks of 32 pins, an 8-bit address and two synchronizer stages. With three banks the fourth bank slot of the address decode is empty. A write there therefore shows at once whether it aliases onto bank 0. Pin 95 exercises the top boundary of the pin vector. The two-stage synchronizer gives a fixed three-edge latency from input to status, which the bench checks edge by edge. It also checks that a held level sets its status bit again in the cycle right after a clear.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  typedef enum logic [3:0] {
    RT_DIR  = 4'd0,
    RT_INV  = 4'd1,
    RT_LVL  = 4'd2,
    RT_SET  = 4'd3,
    RT_CLR  = 4'd4,
    RT_RISE = 4'd5,
    RT_FALL = 4'd6,
    RT_HIGH = 4'd7,
    RT_LOW  = 4'd8,
    RT_STAT = 4'd9,
    RT_KIND = 4'd10
  } reg_type_e;

  localparam int unsigned NUM_TYPES  = 11;
  localparam int unsigned BANK_SLOTS = 4;  // 4-byte bank stride inside a 16-byte type stride
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 96,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_type_e         wtype_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  reg_type_e         rtype_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [BANK_W-1:0] pin_i,
  output logic [BANK_W-1:0] pad_o,
  output logic [BANK_W-1:0] oe_o,
  output logic [BANK_W-1:0] pend_o
);
  logic [BANK_W-1:0] dir_q, inv_q, out_q, rise_q, fall_q, high_q, low_q;
  logic [BANK_W-1:0] stat_q, kind_q, prev_q;
  logic [BANK_W-1:0] lvl_n, edge_evt, level_evt, w1c, stat_d, kind_d;

  always_comb begin
    lvl_n     = pin_i ^ inv_q;
    edge_evt  = (rise_q & lvl_n & ~prev_q) | (fall_q & ~lvl_n & prev_q);
    level_evt = (high_q & lvl_n) | (low_q & ~lvl_n);
    w1c       = (wr_i && wtype_i == RT_STAT) ? wdata_i : '0;
    // edges win over a clear in the same cycle; levels re-arm a cycle later
    stat_d    = (stat_q & ~w1c) | edge_evt | (level_evt & ~w1c);
    kind_d    = edge_evt | (kind_q & ~level_evt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      inv_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      high_q <= '0;
      low_q  <= '0;
      stat_q <= '0;
      kind_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= lvl_n;
      stat_q <= stat_d;
      kind_q <= kind_d;
      if (wr_i) begin
        case (wtype_i)
          RT_DIR:  dir_q  <= wdata_i;
          RT_INV:  inv_q  <= wdata_i;
          RT_SET:  out_q  <= out_q | wdata_i;
          RT_CLR:  out_q  <= out_q & ~wdata_i;
          RT_RISE: rise_q <= wdata_i;
          RT_FALL: fall_q <= wdata_i;
          RT_HIGH: high_q <= wdata_i;
          RT_LOW:  low_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rtype_i)
      RT_DIR:  rdata_o = dir_q;
      RT_INV:  rdata_o = inv_q;
      RT_LVL:  rdata_o = (dir_q & out_q) | (~dir_q & pin_i);
      RT_RISE: rdata_o = rise_q;
      RT_FALL: rdata_o = fall_q;
      RT_HIGH: rdata_o = high_q;
      RT_LOW:  rdata_o = low_q;
      RT_STAT: rdata_o = stat_q;
      RT_KIND: rdata_o = kind_q & stat_q;
      default: rdata_o = '0;
    endcase
  end

  assign pad_o  = out_q;
  assign oe_o   = dir_q;
  assign pend_o = stat_q;
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 3,
  parameter int unsigned BANK_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_PINS   = NUM_BANKS * BANK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [BANK_W-1:0]   wdata_i,
  input  logic                rd_en_i,
  output logic [BANK_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] gpio_i,
  output logic [NUM_PINS-1:0] gpio_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  output logic                irq_o
);
  localparam int unsigned TYPE_W = ADDR_W - 4;

  logic [TYPE_W-1:0]   type_f;
  logic [1:0]          bank_f;
  logic                hit;
  reg_type_e           rtype;
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] pend_all;
  logic [BANK_W-1:0]   bank_rd [BANK_SLOTS];
  logic [BANK_W-1:0]   rd_val, rdata_q;

  assign type_f = addr_i[ADDR_W-1:4];
  assign bank_f = addr_i[3:2];
  assign hit    = (addr_i[1:0] == 2'b00) &&
                  ({1'b0, bank_f} < 3'(NUM_BANKS)) &&
                  (type_f < TYPE_W'(NUM_TYPES));
  assign rtype  = reg_type_e'(type_f[3:0]);

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_s)
  );

  for (genvar b = 0; b < BANK_SLOTS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_on
      gpio_bank #(.BANK_W(BANK_W)) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr_en_i && hit && (bank_f == 2'(b))),
        .wtype_i(rtype),
        .wdata_i(wdata_i),
        .rtype_i(rtype),
        .rdata_o(bank_rd[b]),
        .pin_i  (pin_s[b*BANK_W +: BANK_W]),
        .pad_o  (gpio_o[b*BANK_W +: BANK_W]),
        .oe_o   (gpio_oe_o[b*BANK_W +: BANK_W]),
        .pend_o (pend_all[b*BANK_W +: BANK_W])
      );
    end else begin : g_off
      assign bank_rd[b] = '0;
    end
  end

  assign rd_val = hit ? bank_rd[bank_f] : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en_i ? rd_val : '0;

  assign rdata_o = rdata_q;
  assign irq_o   = |pend_all;
endmodule

// File: rtl/gpio_bank_ctl_chk.sv
module gpio_bank_ctl_chk #(
  parameter int unsigned BANK_W   = 32,
  parameter int unsigned NUM_PINS = 96
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [BANK_W-1:0]   rdata_o,
  input logic [NUM_PINS-1:0] gpio_o,
  input logic [NUM_PINS-1:0] gpio_oe_o,
  input logic                irq_o
);
  AST_OE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gpio_oe_o) |-> $past(wr_en_i)); // R3

  AST_OUT_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gpio_o) |-> $past(wr_en_i)); // R4

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> (rdata_o == '0)); // R5

  AST_IRQ_FALL_NEEDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i)); // R11

  AST_RDATA_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(rdata_o)); // R5
endmodule

bind gpio_bank_ctl gpio_bank_ctl_chk #(.BANK_W(BANK_W), .NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .rdata_o  (rdata_o),
  .gpio_o   (gpio_o),
  .gpio_oe_o(gpio_oe_o),
  .irq_o    (irq_o)
);

// File: tb/gpio_bank_ctl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [95:0] gin = '0;
  logic [95:0] gout, goe;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gpio_bank_ctl u_gpio_bank_ctl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .gpio_i(gin), .gpio_o(gout),
    .gpio_oe_o(goe), .irq_o(irq)
  );

  function automatic logic [7:0] ra(input int t, input int b);
    return 8'(t * 16 + b * 4);
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R2 gpio_o", gout, '0);
    chk("R2 gpio_oe_o", goe, '0);
    chk("R2 irq_o", 96'(irq), '0);
    rd(ra(0, 0), d); chk("R2 dir bank0", 96'(d), '0);
    rd(ra(9, 2), d); chk("R2 status bank2", 96'(d), '0);
  endtask

  task automatic t_outputs;
    logic [31:0] d;
    wr(ra(0, 2), 32'hFFFF_0000);
    chk("R3 R1 oe bank2", goe, {32'hFFFF_0000, 64'h0});
    wr(ra(3, 2), 32'h00F0_00F0);
    chk("R4 set", gout, {32'h00F0_00F0, 64'h0});
    wr(ra(4, 2), 32'h0000_00F0);
    chk("R4 clear", gout, {32'h00F0_0000, 64'h0});
    @(negedge clk); gin[95:64] = 32'h0000_00AA;
    idle(3);
    rd(ra(2, 2), d); chk("R5 level mix", 96'(d), 96'(32'h00F0_00AA));
    rd(ra(3, 2), d); chk("R12 set reads zero", 96'(d), '0);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(ra(5, 1), 32'h20);
    @(negedge clk); gin[37] = 1'b1;
    @(negedge clk); chk("R6 edge 1", 96'(irq), '0);
    @(negedge clk); chk("R6 edge 2", 96'(irq), '0);
    @(negedge clk); chk("R6 edge 3", 96'(irq), 96'(1));
    rd(ra(9, 1), d); chk("R7 rise status", 96'(d), 96'(32'h20));
    rd(ra(10, 1), d); chk("R10 kind edge", 96'(d), 96'(32'h20));
    wr(ra(9, 1), 32'h20);
    chk("R9 edge clear irq", 96'(irq), '0);
    rd(ra(9, 1), d); chk("R9 edge stays clear", 96'(d), '0);
    @(negedge clk); gin[37] = 1'b0;
    idle(4); chk("R7 fall not enabled", 96'(irq), '0);
    wr(ra(5, 1), 32'h0);
    @(negedge clk); gin[37] = 1'b1;
    idle(4); chk("R7 both edges masked", 96'(irq), '0);
    wr(ra(6, 1), 32'h20);
    @(negedge clk); gin[37] = 1'b0;
    idle(4);
    rd(ra(9, 1), d); chk("R7 fall status", 96'(d), 96'(32'h20));
    wr(ra(6, 1), 32'h0);
    wr(ra(9, 1), 32'h20);
    chk("R9 fall cleared", 96'(irq), '0);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    wr(ra(7, 0), 32'h08);
    @(negedge clk); gin[3] = 1'b1;
    idle(4);
    rd(ra(9, 0), d); chk("R8 high status", 96'(d), 96'(32'h08));
    rd(ra(10, 0), d); chk("R10 kind level", 96'(d), '0);
    wr(ra(9, 0), 32'h08);
    chk("R9 level cleared", 96'(irq), '0);
    @(negedge clk); chk("R9 level re-set", 96'(irq), 96'(1));
    wr(ra(7, 0), 32'h0);
    @(negedge clk); gin[3] = 1'b0;
    wr(ra(9, 0), 32'h08);
    idle(4); chk("R8 high disabled", 96'(irq), '0);
    wr(ra(1, 0), 32'h08);
    wr(ra(8, 0), 32'h08);
    idle(4); chk("R8 low blocked by inversion", 96'(irq), '0);
    rd(ra(1, 0), d); chk("R1 inversion readback", 96'(d), 96'(32'h08));
    @(negedge clk); gin[3] = 1'b1;
    idle(4);
    rd(ra(9, 0), d); chk("R8 inverted low status", 96'(d), 96'(32'h08));
    wr(ra(8, 0), 32'h0);
    wr(ra(9, 0), 32'h08);
    chk("R8 low cleared", 96'(irq), '0);
    wr(ra(1, 0), 32'h0);
    @(negedge clk); gin[3] = 1'b0;
    idle(4);
  endtask

  task automatic t_multi;
    logic [31:0] d;
    wr(ra(5, 0), 32'h1);
    wr(ra(5, 2), 32'h8000_0000);
    @(negedge clk); gin[0] = 1'b1; gin[95] = 1'b1;
    idle(4);
    chk("R11 irq two banks", 96'(irq), 96'(1));
    rd(ra(9, 2), d); chk("R1 status bank2 pin95", 96'(d), 96'(32'h8000_0000));
    rd(ra(9, 1), d); chk("R1 status bank1 idle", 96'(d), '0);
    wr(ra(9, 0), 32'hFFFF_FFFE);
    rd(ra(9, 0), d); chk("R9 zero bits keep", 96'(d), 96'(32'h1));
    wr(ra(9, 0), 32'h1);
    chk("R11 irq other bank pending", 96'(irq), 96'(1));
    wr(ra(9, 2), 32'h8000_0000);
    chk("R11 irq all clear", 96'(irq), '0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'hB0, d); chk("R12 type 11 read", 96'(d), '0);
    rd(8'h09, d); chk("R12 unaligned read", 96'(d), '0);
    rd(8'h0C, d); chk("R12 bank3 read", 96'(d), '0);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h09, 32'hFFFF_FFFF);
    wr(8'hF0, 32'hFFFF_FFFF);
    wr(ra(2, 0), 32'hFFFF_FFFF);
    wr(ra(10, 0), 32'hFFFF_FFFF);
    chk("R12 oe untouched", goe, {32'hFFFF_0000, 64'h0});
    chk("R12 out untouched", gout, {32'h00F0_0000, 64'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_outputs;
    t_edges;
    t_levels;
    t_multi;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule